// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Array

This block holds 2048 bytes of shared counters that a processor reaches through a load/store I/O window. A load is an atomic fetch-and-add. The signed increment travels in the upper address field rather than in the data, and the response returns the operand's value from before the update. A store either adds its data to the addressed counter or replaces it. Operands are 8, 16, 32 or 64 bits wide. Counters of one size can share an 8-byte group with counters of another size, and an operation touches only its own bytes.

On a load, one address bit asks the block to hold the operation until an external "tag switch done" signal is high. If that signal does not arrive within a fixed number of cycles, the load is abandoned without touching the counter. Its response then carries only an error flag in the most significant bit. A request whose address is not a multiple of its operand size gets the same error response, and storage is left unchanged.

The block applies at most one operation per cycle. A request with no wait is answered in the cycle after it is accepted, so any later request to the same counter sees the earlier result.

Top module: `fetch_add_array`

## Requirements
- R1: After reset every counter byte reads as zero, `reqReady` is high and `rspValid` is low.
- R2: A load uses byte address `reqAddr[10:0]` and operand size `reqSize` (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). It returns the old operand value sign-extended to 64 bits. The counter becomes the old value plus the increment in `reqAddr[35:14]`, read as a 22-bit signed value and sign-extended. The sum wraps modulo 2^size.
- R3: On a store, `reqAddr[13]` = 0 adds the low operand bits of `reqData` to the counter, with wrap-around. `reqAddr[13]` = 1 overwrites the counter with those bits. A store's response data is zero.
- R4: Bytes are little-endian within each 8-byte group: byte address a holds bits [(a mod 8)*8 +: 8] of the group. An operation changes only the bytes its size covers.
- R5: A 16-, 32- or 64-bit request whose byte address is not a multiple of 2, 4 or 8 gets the response 0x8000_0000_0000_0000 one cycle after acceptance and changes no storage. This holds even when `reqAddr[13]` is set.
- R6: A load with `reqAddr[13]` = 1 runs at once if `tagDone` is high when it is accepted. Otherwise the block keeps `reqReady` low and gives no response until the first cycle in which `tagDone` is high, and then performs the load.
- R7: If `tagDone` stays low for TIMEOUT_CYCLES (default 256) waiting cycles, the load gets the response 0x8000_0000_0000_0000 and the counter is left unchanged.
- R8: Every accepted request yields exactly one response, in order. A request that does not wait is answered in the cycle after acceptance. Requests accepted in consecutive cycles on the same counter each see the previous one's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqIsLoad | input | 1 | 1 = load (fetch-and-add), 0 = store |
| reqSize | input | 2 | Operand size code |
| reqAddr | input | 36 | Address word: byte address, mode/wait bit, load increment |
| reqData | input | 64 | Store data |
| tagDone | input | 1 | External tag switch has completed |
| rspValid | output | 1 | Response present for one cycle |
| rspData | output | 64 | Old value, zero for stores, or error flag |

## Verification
The hardest states to reach are a waiting load that is released by `tagDone` and one that runs out its whole timeout. Neither shows at the ports while it is in progress; only `reqReady` staying low and the absence of a response reveal it. The stimulus holds `tagDone` low across a waiting load and counts responses while the block stalls. It releases the load after a few cycles in one case and lets the full timeout expire in the other. A follow-up load then proves that the abandoned add never reached the counter. Mixed-size traffic within one 8-byte group, and back-to-back requests on a single counter, cover byte placement and read-after-write ordering.

// File: rtl/faa_pkg.sv
package faa_pkg;
  // Operand size codes carried on reqSize.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } opSize_e;

  // Strobes from control to datapath; at most one is set in any cycle.
  typedef struct packed {
    logic applyOp;
    logic timeoutErr;
    logic alignErr;
  } ctrlStrobe_t;
endpackage

// File: rtl/faa_ctrl.sv
module faa_ctrl
  import faa_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64,
  parameter int MODE_BIT = 13,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsLoad,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              tagDone,
  output logic              opIsLoad,
  output logic [1:0]        opSize,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output ctrlStrobe_t       strobe
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e            state;
  logic [CNT_W-1:0]  waitCnt;
  logic              heldIsLoad;
  logic [1:0]        heldSize;
  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldData;
  logic              accept;
  logic              liveWait;
  logic              liveBad;

  function automatic logic isMisaligned(input logic [1:0] sz, input logic [2:0] off);
    case (opSize_e'(sz))
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return |off[1:0];
      default: return |off;
    endcase
  endfunction

  always_comb begin
    reqReady = (state == ST_IDLE);
    accept   = reqValid && reqReady;
    liveWait = reqIsLoad && reqAddr[MODE_BIT] && !tagDone;
    liveBad  = isMisaligned(reqSize, reqAddr[2:0]);
    if (state == ST_IDLE) begin
      opIsLoad = reqIsLoad;
      opSize   = reqSize;
      opAddr   = reqAddr;
      opData   = reqData;
    end else begin
      opIsLoad = heldIsLoad;
      opSize   = heldSize;
      opAddr   = heldAddr;
      opData   = heldData;
    end
    strobe = '0;
    if (accept) begin
      if (liveBad) strobe.alignErr = 1'b1;
      else if (!liveWait) strobe.applyOp = 1'b1;
    end else if (state == ST_WAIT) begin
      if (tagDone) strobe.applyOp = 1'b1;
      else if (waitCnt == LAST_WAIT) strobe.timeoutErr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      heldIsLoad <= 1'b0;
      heldSize   <= '0;
      heldAddr   <= '0;
      heldData   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && !liveBad && liveWait) begin
            state      <= ST_WAIT;
            waitCnt    <= '0;
            heldIsLoad <= reqIsLoad;
            heldSize   <= reqSize;
            heldAddr   <= reqAddr;
            heldData   <= reqData;
          end
        end
        default: begin
          if (tagDone || waitCnt == LAST_WAIT) state <= ST_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/faa_alu.sv
module faa_alu
  import faa_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] curWord,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] operand,
  input  logic              overwrite,
  output logic [DATA_W-1:0] newWord,
  output logic [DATA_W-1:0] oldExt
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] placed;
  logic [LANES-1:0]  laneEn;

  always_comb begin
    shifted = curWord >> {byteOff, 3'b000};
    case (opSize_e'(opSize))
      SZ_BYTE: widthMask = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_HALF: widthMask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      SZ_WORD: widthMask = {{(DATA_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: widthMask = '1;
    endcase
    oldVal = shifted & widthMask;
    sum    = overwrite ? operand : (oldVal + operand);
    placed = (sum & widthMask) << {byteOff, 3'b000};
    case (opSize_e'(opSize))
      SZ_BYTE: oldExt = {{(DATA_W-8){oldVal[7]}}, oldVal[7:0]};
      SZ_HALF: oldExt = {{(DATA_W-16){oldVal[15]}}, oldVal[15:0]};
      SZ_WORD: oldExt = {{(DATA_W-32){oldVal[31]}}, oldVal[31:0]};
      default: oldExt = oldVal;
    endcase
  end

  // A lane is covered when it falls in the same size-aligned slot as the offset.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEn[g] = ((OFF_W'(g) >> opSize) == (byteOff >> opSize));
    assign newWord[g*8 +: 8] = laneEn[g] ? placed[g*8 +: 8] : curWord[g*8 +: 8];
  end
endmodule

// File: rtl/faa_dpath.sv
module faa_dpath
  import faa_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64,
  parameter int ARRAY_BYTES = 2048,
  parameter int INC_LSB = 14,
  parameter int INC_W = 22,
  parameter int MODE_BIT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opIsLoad,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  ctrlStrobe_t       strobe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int WORDS = ARRAY_BYTES / LANES;
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [DATA_W-1:0] ERR_RSP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  wordIdx;
  logic [OFF_W-1:0]  byteOff;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] incr;
  logic [DATA_W-1:0] operand;
  logic              overwrite;
  logic [DATA_W-1:0] newWord;
  logic [DATA_W-1:0] oldExt;
  logic              unusedAddr;

  assign unusedAddr = ^opAddr;
  assign wordIdx    = opAddr[OFF_W +: IDX_W];
  assign byteOff    = opAddr[OFF_W-1:0];
  assign curWord    = mem[wordIdx];
  assign incr       = {{(DATA_W-INC_W){opAddr[INC_LSB+INC_W-1]}}, opAddr[INC_LSB +: INC_W]};
  assign operand    = opIsLoad ? incr : opData;
  assign overwrite  = !opIsLoad && opAddr[MODE_BIT];

  faa_alu #(.DATA_W(DATA_W)) alu_i (
    .curWord  (curWord),
    .byteOff  (byteOff),
    .opSize   (opSize),
    .operand  (operand),
    .overwrite(overwrite),
    .newWord  (newWord),
    .oldExt   (oldExt)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      rspValid <= strobe.applyOp || strobe.timeoutErr || strobe.alignErr;
      if (strobe.applyOp) begin
        mem[wordIdx] <= newWord;
        rspData      <= opIsLoad ? oldExt : '0;
      end else if (strobe.timeoutErr || strobe.alignErr) begin
        rspData <= ERR_RSP;
      end
    end
  end
endmodule

// File: rtl/fetch_add_array.sv
module fetch_add_array
  import faa_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64,
  parameter int ARRAY_BYTES = 2048,
  parameter int INC_LSB = 14,
  parameter int INC_W = 22,
  parameter int MODE_BIT = 13,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsLoad,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              tagDone,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic              opIsLoad;
  logic [1:0]        opSize;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  ctrlStrobe_t       strobe;

  faa_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_BIT(MODE_BIT), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsLoad(reqIsLoad), .reqSize(reqSize), .reqAddr(reqAddr), .reqData(reqData),
    .tagDone(tagDone), .opIsLoad(opIsLoad), .opSize(opSize), .opAddr(opAddr),
    .opData(opData), .strobe(strobe)
  );

  faa_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_BYTES(ARRAY_BYTES),
    .INC_LSB(INC_LSB), .INC_W(INC_W), .MODE_BIT(MODE_BIT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .opIsLoad(opIsLoad), .opSize(opSize), .opAddr(opAddr),
    .opData(opData), .strobe(strobe), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/fetch_add_array_chk.sv
module fetch_add_array_chk #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64,
  parameter int MODE_BIT = 13,
  parameter int TIMEOUT_CYCLES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqIsLoad,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqData,
  input logic              tagDone,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData
);
  localparam logic [DATA_W-1:0] ERR_RSP = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2);

  logic             accepted;
  logic             waitReq;
  logic             badAlign;
  logic [RUN_W-1:0] stallRun;
  logic             unusedData;

  assign unusedData = ^reqData;
  assign accepted   = reqValid && reqReady;
  assign waitReq    = reqIsLoad && reqAddr[MODE_BIT];

  always_comb begin
    case (reqSize)
      2'd0:    badAlign = 1'b0;
      2'd1:    badAlign = reqAddr[0];
      2'd2:    badAlign = reqAddr[1] | reqAddr[0];
      default: badAlign = reqAddr[2] | reqAddr[1] | reqAddr[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stallRun <= '0;
    else if (reqReady) stallRun <= '0;
    else stallRun <= stallRun + 1'b1;
  end

  assert_prompt_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !waitReq |=> rspValid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(accepted) || !$past(reqReady)));

  assert_store_ack_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !reqIsLoad && !badAlign |=> rspData == '0);

  assert_misalign_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    accepted && badAlign |=> rspValid && rspData == ERR_RSP);

  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    accepted && waitReq && !badAlign && !tagDone |=> !rspValid && !reqReady);

  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    stallRun <= RUN_W'(TIMEOUT_CYCLES));
endmodule

bind fetch_add_array fetch_add_array_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_BIT(MODE_BIT), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqIsLoad(reqIsLoad), .reqSize(reqSize), .reqAddr(reqAddr), .reqData(reqData),
  .tagDone(tagDone), .rspValid(rspValid), .rspData(rspData)
);

// File: tb/fetch_add_array_tb_top.sv
module fetch_add_array_tb_top;
  localparam int TMO = 256;
  localparam logic [63:0] ERR = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqIsLoad = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [35:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic        tagDone = 1'b1;
  logic        rspValid;
  logic [63:0] rspData;

  int checks = 0;
  int errors = 0;
  int rspCount = 0;
  int snap = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  mdlMem [2048];
  logic [63:0] monExp;
  string       monTag;

  always #2 clk = ~clk;

  fetch_add_array dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsLoad(reqIsLoad), .reqSize(reqSize), .reqAddr(reqAddr), .reqData(reqData),
    .tagDone(tagDone), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic void check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [63:0] mdlRd(int a, int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = mdlMem[a+i];
    return r;
  endfunction

  function automatic void mdlWr(int a, int sz, logic [63:0] v);
    for (int i = 0; i < (1 << sz); i++) mdlMem[a+i] = v[i*8 +: 8];
  endfunction

  function automatic logic [63:0] sx(logic [63:0] v, int sz);
    case (sz)
      0: return {{56{v[7]}}, v[7:0]};
      1: return {{48{v[15]}}, v[15:0]};
      2: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  // Driver: computes the expected response, queues it, then performs the handshake.
  task automatic issue(input bit isLoad, input int sz, input int byteAddr, input bit flag,
                       input logic [63:0] value, input bit expTimeout, input string tag);
    logic [35:0] a = '0;
    logic [63:0] old;
    a[10:0] = 11'(byteAddr);
    a[13] = flag;
    if (isLoad) a[35:14] = value[21:0];
    if ((byteAddr % (1 << sz)) != 0 || expTimeout) begin
      expQ.push_back(ERR);
    end else begin
      old = mdlRd(byteAddr, sz);
      if (isLoad) begin
        expQ.push_back(sx(old, sz));
        mdlWr(byteAddr, sz, old + value);
      end else begin
        expQ.push_back('0);
        mdlWr(byteAddr, sz, flag ? value : old + value);
      end
    end
    tagQ.push_back(tag);
    reqValid  = 1'b1;
    reqIsLoad = isLoad;
    reqSize   = 2'(sz);
    reqAddr   = a;
    reqData   = isLoad ? 64'h0 : value;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && expQ.size() != 0; i++) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever the design responds.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspCount++;
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8 unexpected response act=%h exp=none", rspData);
      end else begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        check(rspData === monExp, monTag, rspData, monExp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", expQ.size());
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mdlMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R1 ready after reset", 64'(reqReady), 64'd1);
    check(rspValid === 1'b0, "R1 no response after reset", 64'(rspValid), 64'd0);
    issue(1, 3, 0, 0, 0, 0, "R1 counter 0 reset");
    issue(1, 3, 2040, 0, 0, 0, "R1 last counter reset");

    // R2: 64-bit fetch-and-add with positive, negative and extreme increments
    issue(1, 3, 8, 0, 5, 0, "R2 add 5");
    issue(1, 3, 8, 0, -64'sd3, 0, "R2 add -3");
    issue(1, 3, 8, 0, 0, 0, "R2 read 2");
    issue(1, 3, 16, 0, 64'h1F_FFFF, 0, "R2 max increment");
    issue(1, 3, 16, 0, -64'sh20_0000, 0, "R2 min increment");
    issue(1, 3, 16, 0, 0, 0, "R2 result -1");
    // R2 8-bit wrap; R4 neighbours untouched
    issue(0, 0, 33, 1, 64'hFF, 0, "R3 overwrite byte");
    issue(1, 0, 33, 0, 1, 0, "R2 byte old 0xff");
    issue(1, 0, 33, 0, 0, 0, "R2 byte wrapped");
    issue(1, 0, 32, 0, 0, 0, "R4 lower neighbour");
    issue(1, 0, 34, 0, 0, 0, "R4 upper neighbour");
    // R2 16-bit and 32-bit
    issue(0, 1, 64, 1, 64'h8000, 0, "R3 overwrite half");
    issue(1, 1, 64, 0, -64'sd1, 0, "R2 half negative old");
    issue(1, 1, 64, 0, 0, 0, "R2 half 0x7fff");
    issue(0, 2, 260, 1, 64'hFFFF_FFFF, 0, "R3 overwrite word");
    issue(1, 2, 260, 0, 1, 0, "R2 word old -1");
    issue(1, 2, 260, 0, 0, 0, "R2 word wrapped");
    issue(1, 2, 256, 0, 0, 0, "R4 adjacent word");
    // R3 store add and overwrite
    issue(0, 3, 512, 0, 64'd100, 0, "R3 store add");
    issue(0, 3, 512, 0, 64'h1_0000_0000, 0, "R3 store add wide");
    issue(1, 3, 512, 0, 0, 0, "R3 sum readback");
    issue(0, 3, 512, 1, 64'd7, 0, "R3 store overwrite");
    issue(1, 3, 512, 0, 0, 0, "R3 overwrite readback");
    issue(0, 0, 512, 0, 64'hFFFF_FFFF_FFFF_FF09, 0, "R3 byte store uses low bits");
    issue(1, 3, 512, 0, 0, 0, "R3 byte store readback");
    // R4 little-endian layout
    issue(0, 3, 768, 1, 64'h8877_6655_4433_2211, 0, "R4 fill group");
    issue(1, 0, 768, 0, 0, 0, "R4 byte 0");
    issue(1, 0, 775, 0, 0, 0, "R4 byte 7");
    issue(1, 1, 770, 0, 0, 0, "R4 half at 2");
    issue(1, 2, 772, 0, 0, 0, "R4 word at 4");
    // R5 misaligned
    issue(1, 1, 769, 0, 1, 0, "R5 half odd");
    issue(1, 2, 770, 0, 1, 0, "R5 word at 2");
    issue(1, 3, 772, 1, 1, 0, "R5 dword at 4 with wait bit");
    issue(0, 3, 769, 1, 64'd0, 0, "R5 store misaligned");
    issue(1, 3, 768, 0, 0, 0, "R5 group unchanged");
    // R8 back-to-back on one counter
    for (int k = 0; k < 10; k++) issue(1, 3, 1024, 0, 1, 0, "R8 back-to-back");
    issue(0, 3, 1024, 0, 64'd5, 0, "R8 store between");
    issue(1, 3, 1024, 0, 0, 0, "R8 sees store");
    drain();

    // R6 wait with tagDone already high
    tagDone = 1'b1;
    issue(1, 3, 1280, 1, 2, 0, "R6 immediate when done");
    drain();
    // R6 wait with tagDone low, released later
    tagDone = 1'b0;
    snap = rspCount;
    issue(1, 3, 1280, 1, 3, 0, "R6 released load");
    repeat (6) @(negedge clk);
    check(rspCount == snap, "R6 no response while waiting", 64'(rspCount), 64'(snap));
    check(reqReady === 1'b0, "R6 ready low while waiting", 64'(reqReady), 64'd0);
    tagDone = 1'b1;
    repeat (3) @(negedge clk);
    check(rspCount == snap + 1, "R6 response after release", 64'(rspCount), 64'(snap + 1));
    issue(1, 3, 1280, 0, 0, 0, "R6 counter updated");
    drain();

    // R7 timeout
    tagDone = 1'b0;
    snap = rspCount;
    issue(1, 3, 1280, 1, 10, 1, "R7 timeout error");
    repeat (TMO - 4) @(negedge clk);
    check(rspCount == snap, "R7 no early response", 64'(rspCount), 64'(snap));
    for (int i = 0; i < 12 && rspCount == snap; i++) @(negedge clk);
    check(rspCount == snap + 1, "R7 timeout response arrived", 64'(rspCount), 64'(snap + 1));
    tagDone = 1'b1;
    issue(1, 3, 1280, 0, 0, 0, "R7 counter unchanged");
    drain();

    check(expQ.size() == 0, "R8 all responses received", 64'(expQ.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule